// File: doc/BRIEF.md
# Modem Status Indicator Port

This block turns the state flags of a power-line modem controller into four single-bit status pins for a host microcontroller. A reception indicator shows one of three conditions on one wire. It blinks at a slow rate while the modem waits for configuration. It sits low once the synchronisation confirm window has expired. It sits high while the modem searches for mains-locked synchronisation.

A second pin reports a good frame check. It is raised only inside the gap between two time slots, and only when the last received frame checked out. A third pin is shared: a mode bit chooses between the bit currently being sent and a strobe that marks the approach of a time slot. The last pin is an active-low enable for an external line driver. It asserts as soon as the transmitter is active and is held until the bit period in progress has ended.

All four outputs are registered, so each one follows its inputs by one clock. Outside their active conditions the open-drain-style pins rest high. The blink rate comes from a parameterised divider of the system clock. The pad drivers sit outside this block.

Top module: `modem_status_port`

## Requirements
- R1: After a synchronous active-low reset, rx_ind = 1, crc_ind = 0, data_slot = 1 and tx_en_n = 1.
- R2: While cfg_wait = 1, rx_ind is a square wave with 50% duty cycle. Its period is 2*HALF_CYCLES clocks. It starts low in the first clock after cfg_wait rises, and the phase restarts whenever cfg_wait has been low.
- R3: When sync_timeout = 1 and cfg_wait = 0, rx_ind is 0 one clock later.
- R4: When sync_search = 1 and both cfg_wait and sync_timeout are 0, rx_ind is 1 one clock later. When no reception flag is set, rx_ind is also 1.
- R5: crc_ind is 1 one clock after a cycle in which slot_pause = 1 and crc_ok = 1. In every other case it is 0.
- R6: tx_en_n is 0 in the clock after any cycle with tx_active = 1.
- R7: Once tx_active has fallen, tx_en_n stays 0 until a cycle with bit_end = 1. It reads 1 in the clock after that cycle, and this includes the case where tx_active falls in the same cycle as bit_end.
- R8: With slot_mode = 0, data_slot shows tx_bit one clock later while tx_active = 1, and shows 1 while tx_active = 0.
- R9: With slot_mode = 1, data_slot is the inverse of pre_slot one clock later, so the strobe drives the pin low. tx_bit is ignored in this mode.
- R10: The reception flags have a fixed priority: cfg_wait first, then sync_timeout, then sync_search.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_wait | input | 1 | Modem is waiting for configuration |
| sync_search | input | 1 | Modem is searching for synchronisation |
| sync_timeout | input | 1 | Synchronisation confirm window has expired |
| crc_ok | input | 1 | Last received frame passed its check |
| slot_pause | input | 1 | Currently in the pause between time slots |
| tx_active | input | 1 | Transmitter is active |
| bit_end | input | 1 | One-clock strobe at the end of a transmitted bit period |
| tx_bit | input | 1 | Bit currently being transmitted |
| slot_mode | input | 1 | 0: shared pin shows data, 1: shared pin shows pre-slot strobe |
| pre_slot | input | 1 | Pre-slot synchronisation strobe, active high |
| rx_ind | output | 1 | Reception state indicator |
| crc_ind | output | 1 | Good-frame indicator during slot pause |
| data_slot | output | 1 | Shared transmit-data / pre-slot output |
| tx_en_n | output | 1 | Line driver enable, active low |

## Verification
Two events can land in the same clock: tx_active falling and the bit_end strobe that closes the final bit period. The bench drops tx_active and pulses bit_end together and expects tx_en_n to read 1 one clock later. It then repeats the sequence with bit_end arriving several clocks after the drop, and expects the enable to be held until then. A second collision is a blink toggle falling in the same clock as a change of the higher-priority reception flag. The bench provokes this by sweeping all flag combinations after a blink run, and judges it by checking that rx_ind follows the priority order and that a new blink starts low.

// File: rtl/modem_status_pkg.sv
// Package: shared types for the modem status indicator port.
// Assumes: nothing beyond IEEE 1800-2017.
package modem_status_pkg;

    // Selected behaviour of the reception indicator pin
    typedef enum logic [1:0] {
        RXS_IDLE   = 2'd0,
        RXS_BLINK  = 2'd1,
        RXS_LOW    = 2'd2,
        RXS_HIGH   = 2'd3
    } rx_show_e;

endpackage

// File: rtl/msp_blink_gen.sv
// Module: msp_blink_gen
// Produces a 50% duty square wave whose half period is HALF_CYCLES clocks.
// Assumes: run is a level; when run is low the phase is parked low and the
// counter is cleared, so every new run starts with a full low half period.
module msp_blink_gen #(
    parameter int HALF_CYCLES = 2_500_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic phase
);
    localparam int CW = (HALF_CYCLES > 1) ? $clog2(HALF_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_CYCLES - 1);

    logic [CW-1:0] cnt_q;
    logic          phase_q;

    // Count clocks of the current half period and flip phase at its end
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q   <= '0;
            phase_q <= 1'b0;
        end else if (cnt_q == LAST) begin
            cnt_q   <= '0;
            phase_q <= ~phase_q;
        end else begin
            cnt_q   <= cnt_q + 1'b1;
        end
    end

    assign phase = phase_q;

    AST_BLINK_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);                                                   // R2
    AST_BLINK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        run && (cnt_q != LAST) |=> $stable(phase_q));                     // R2
    AST_BLINK_PARK: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !phase_q);                                               // R2

endmodule

// File: rtl/msp_rx_encoder.sv
// Module: msp_rx_encoder
// Folds the three reception flags onto one pin: blink, steady low, steady high.
// Assumes: priority cfg_wait > sync_timeout > sync_search; blink phase is
// supplied by msp_blink_gen and is low on the first clock of a new wait.
module msp_rx_encoder
    import modem_status_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_wait,
    input  logic sync_timeout,
    input  logic sync_search,
    input  logic blink_phase,
    output logic rx_ind
);
    rx_show_e show;
    logic     rx_q;

    // Pick the displayed behaviour by flag priority
    always_comb begin
        if (cfg_wait)          show = RXS_BLINK;
        else if (sync_timeout) show = RXS_LOW;
        else if (sync_search)  show = RXS_HIGH;
        else                   show = RXS_IDLE;
    end

    // Register the pin level for the selected behaviour
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_q <= 1'b1;
        end else begin
            unique case (show)
                RXS_BLINK: rx_q <= blink_phase;
                RXS_LOW:   rx_q <= 1'b0;
                RXS_HIGH:  rx_q <= 1'b1;
                default:   rx_q <= 1'b1;
            endcase
        end
    end

    assign rx_ind = rx_q;

    AST_RX_TIMEOUT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        sync_timeout && !cfg_wait |=> !rx_ind);                           // R3
    AST_RX_SEARCH_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_wait && !sync_timeout |=> rx_ind);                           // R4

endmodule

// File: rtl/msp_tx_keyer.sv
// Module: msp_tx_keyer
// Drives the active-low line driver enable and the shared data/pre-slot pin.
// Assumes: bit_end is a one-clock strobe at the close of each bit period;
// the enable is held after tx_active falls until such a strobe arrives.
module msp_tx_keyer (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_active,
    input  logic bit_end,
    input  logic tx_bit,
    input  logic slot_mode,
    input  logic pre_slot,
    output logic tx_en_n,
    output logic data_slot
);
    logic en_q;
    logic ds_q;
    logic ds_next;

    // Keep the driver enabled while active and through the final bit period
    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= 1'b0;
        else        en_q <= tx_active | (en_q & ~bit_end);
    end

    // Choose what the shared pin shows
    always_comb begin
        if (slot_mode)      ds_next = ~pre_slot;
        else if (tx_active) ds_next = tx_bit;
        else                ds_next = 1'b1;
    end

    // Register the shared pin
    always_ff @(posedge clk) begin
        if (!rst_n) ds_q <= 1'b1;
        else        ds_q <= ds_next;
    end

    assign tx_en_n   = ~en_q;
    assign data_slot = ds_q;

    AST_TX_ON: assert property (@(posedge clk) disable iff (!rst_n)
        tx_active |=> !tx_en_n);                                          // R6
    AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en_n && !tx_active && !bit_end |=> !tx_en_n);                 // R7
    AST_TX_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_active && bit_end |=> tx_en_n);                               // R7
    AST_SLOT_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        slot_mode && pre_slot |=> !data_slot);                            // R9

endmodule

// File: rtl/modem_status_port.sv
// Module: modem_status_port (top)
// Registers the modem controller's state flags onto four host-facing pins.
// Assumes: all inputs are synchronous to clk; HALF_CYCLES clocks make half
// of the blink period (2.5M at 50 MHz gives 10 Hz).
module modem_status_port #(
    parameter int HALF_CYCLES = 2_500_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_wait,
    input  logic sync_search,
    input  logic sync_timeout,
    input  logic crc_ok,
    input  logic slot_pause,
    input  logic tx_active,
    input  logic bit_end,
    input  logic tx_bit,
    input  logic slot_mode,
    input  logic pre_slot,
    output logic rx_ind,
    output logic crc_ind,
    output logic data_slot,
    output logic tx_en_n
);
    logic blink_phase;
    logic crc_q;

    msp_blink_gen #(.HALF_CYCLES(HALF_CYCLES)) u_blink (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (cfg_wait),
        .phase (blink_phase)
    );

    msp_rx_encoder u_rx (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_wait     (cfg_wait),
        .sync_timeout (sync_timeout),
        .sync_search  (sync_search),
        .blink_phase  (blink_phase),
        .rx_ind       (rx_ind)
    );

    msp_tx_keyer u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .tx_active (tx_active),
        .bit_end   (bit_end),
        .tx_bit    (tx_bit),
        .slot_mode (slot_mode),
        .pre_slot  (pre_slot),
        .tx_en_n   (tx_en_n),
        .data_slot (data_slot)
    );

    // Show a good frame check only inside the slot pause
    always_ff @(posedge clk) begin
        if (!rst_n) crc_q <= 1'b0;
        else        crc_q <= slot_pause & crc_ok;
    end

    assign crc_ind = crc_q;

    AST_CRC_OUTSIDE_PAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_pause |=> !crc_ind);                                        // R5
    AST_CRC_BAD_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        !crc_ok |=> !crc_ind);                                            // R5

endmodule

// File: tb/modem_status_port_bench.sv
module modem_status_port_bench;
    localparam int HALF = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_wait = 0, sync_search = 0, sync_timeout = 0;
    logic crc_ok = 0, slot_pause = 0, tx_active = 0, bit_end = 0;
    logic tx_bit = 0, slot_mode = 0, pre_slot = 0;
    logic rx_ind, crc_ind, data_slot, tx_en_n;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    always #10 clk = ~clk;

    modem_status_port #(.HALF_CYCLES(HALF)) u_modem_status_port (
        .clk(clk), .rst_n(rst_n), .cfg_wait(cfg_wait), .sync_search(sync_search),
        .sync_timeout(sync_timeout), .crc_ok(crc_ok), .slot_pause(slot_pause),
        .tx_active(tx_active), .bit_end(bit_end), .tx_bit(tx_bit),
        .slot_mode(slot_mode), .pre_slot(pre_slot), .rx_ind(rx_ind),
        .crc_ind(crc_ind), .data_slot(data_slot), .tx_en_n(tx_en_n)
    );

    task automatic check(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic report();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        report();
    end

    initial begin
        @(negedge clk);
        step();
        step();
        // R1 reset state
        check("R1 rx_ind", rx_ind, 1'b1);
        check("R1 crc_ind", crc_ind, 1'b0);
        check("R1 data_slot", data_slot, 1'b1);
        check("R1 tx_en_n", tx_en_n, 1'b1);
        rst_n = 1'b1;
        step();

        // R2 blink: four full periods, starting low
        for (int run = 0; run < 2; run++) begin
            cfg_wait = 1'b1;
            for (int i = 0; i < 8 * HALF; i++) begin
                step();
                check("R2 blink", rx_ind, ((i / HALF) % 2) ? 1'b1 : 1'b0);
            end
            cfg_wait = 1'b0;
            step();
        end

        // R3 R4 R10 exhaustive sweep of reception flags
        for (int f = 0; f < 8; f++) begin
            cfg_wait = f[0];
            sync_timeout = f[1];
            sync_search = f[2];
            step();
            if (f[0]) check("R10 wait first, starts low", rx_ind, 1'b0);
            else if (f[1]) check("R3 timeout low", rx_ind, 1'b0);
            else check("R4 search/idle high", rx_ind, 1'b1);
            cfg_wait = 0;
            step();
        end
        sync_timeout = 0;
        sync_search = 0;

        // R5 crc gating sweep
        for (int f = 0; f < 4; f++) begin
            slot_pause = f[0];
            crc_ok = f[1];
            step();
            check("R5 crc", crc_ind, f[0] & f[1]);
        end
        slot_pause = 0;
        crc_ok = 0;

        // R8 R9 shared pin sweep
        for (int f = 0; f < 16; f++) begin
            slot_mode = f[0];
            tx_active = f[1];
            tx_bit = f[2];
            pre_slot = f[3];
            step();
            if (f[0]) check("R9 slot strobe", data_slot, ~f[3]);
            else check("R8 data", data_slot, f[1] ? f[2] : 1'b1);
        end
        slot_mode = 0;
        pre_slot = 0;
        tx_bit = 0;
        tx_active = 0;
        bit_end = 1;
        step();
        bit_end = 0;
        step();
        check("R7 released after sweep", tx_en_n, 1'b1);

        // R6 R7 hold until bit_end
        tx_active = 1;
        step();
        check("R6 enable", tx_en_n, 1'b0);
        tx_active = 0;
        for (int i = 0; i < 3; i++) begin
            step();
            check("R7 hold", tx_en_n, 1'b0);
        end
        bit_end = 1;
        step();
        check("R7 release", tx_en_n, 1'b1);
        bit_end = 0;

        // R7 coincident fall and bit_end
        tx_active = 1;
        step();
        check("R6 enable again", tx_en_n, 1'b0);
        tx_active = 0;
        bit_end = 1;
        step();
        check("R7 coincident release", tx_en_n, 1'b1);

        // R6 bit_end while still active keeps enable
        tx_active = 1;
        bit_end = 1;
        step();
        check("R6 active with bit_end", tx_en_n, 1'b0);
        bit_end = 0;
        tx_active = 0;
        step();
        check("R7 hold after active", tx_en_n, 1'b0);
        bit_end = 1;
        step();
        bit_end = 0;
        check("R7 final release", tx_en_n, 1'b1);

        report();
    end
endmodule